// File: doc/BRIEF.md
# Bus Interrupt Router with Self-Clearing Arm

This block gathers the interrupt requests of four plug-in module sites (two request lines per site, eight in all) and one error line per site (four in all), and presents them to the system bus on seven active-low interrupt lines. Software picks one of two routings. In per-line routing, each request owns a fixed bus line. In shared-level routing, every enabled request and error is merged onto a single bus line chosen by a 3-bit level field. Each source has its own enable bit.

A global arm bit gates all bus interrupt lines. Software sets it with a one-cycle write strobe. The bus interrupt-acknowledge cycle clears it by itself, so every interrupt episode needs an explicit re-arm at the end of the service routine. The bus lines are registered, so they follow the inputs one clock later.

Top module: `irq_router`

## Requirements
- R1: When `route_multi_i`=1 and the block is armed, `irq_n_o[j]` (bus line j+1) goes low exactly when request `req_i[j]` and its enable `req_en_i[j]` are both 1, for j = 0..6. Request index = site*2 + line, with sites A..D numbered 0..3.
- R2: When `route_multi_i`=1, `req_i[7]`, all of `err_i` and `level_i` have no effect on `irq_n_o`.
- R3: When `route_multi_i`=0, `level_i`=L with L in 1..7, and the block is armed, `irq_n_o[L-1]` is low exactly when at least one enabled request or enabled error is 1. All other lines stay high.
- R4: A request or error whose own enable bit (`req_en_i`, `err_en_i`) is 0 never pulls any bus line low.
- R5: While `armed_o` is 0, the next cycle has every bit of `irq_n_o` high.
- R6: A cycle with `arm_set_i`=1 sets `armed_o` on the next cycle. A cycle with `iack_i`=1 clears it on the next cycle. When both are 1 in the same cycle, the clear wins.
- R7: `route_multi_i`=0 selects shared-level routing and 1 selects per-line routing. The mode takes effect on the next cycle's outputs.
- R8: In shared-level routing, `level_i`=0 keeps every bus line high.
- R9: `irq_n_o` is registered: it reflects the inputs and `armed_o` of the previous cycle. All lines are high one cycle after `armed_o` falls.
- R10: After reset, `armed_o` is 0 and all bits of `irq_n_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Module request lines, index site*2+line |
| req_en_i | input | 8 | Per-request enable bits |
| err_i | input | 4 | Module error lines, one per site |
| err_en_i | input | 4 | Per-error enable bits |
| route_multi_i | input | 1 | 1 = per-line routing, 0 = shared level |
| level_i | input | 3 | Bus level for shared routing, 0 = none |
| arm_set_i | input | 1 | Write strobe setting the arm bit |
| iack_i | input | 1 | Bus interrupt-acknowledge indication |
| irq_n_o | output | 7 | Active-low bus lines, bit j = line j+1 |
| armed_o | output | 1 | Current arm bit |

## Verification
Two events can land in one cycle: the acknowledge that clears the arm bit, and a software re-arm strobe. The bench drives both strobes on the same clock while requests are pending. It expects the arm bit low on the next cycle, and all bus lines high one cycle after that. The bench also acknowledges while enabled requests are still active, to confirm that the lines fall silent even though their sources remain asserted.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int unsigned SITES        = 4;
   localparam int unsigned REQ_PER_SITE = 2;
   localparam int unsigned BUS_LINES    = 7;
   localparam int unsigned LEVEL_W      = 3;

   typedef enum logic {
      ROUTE_SHARED = 1'b0,
      ROUTE_MULTI  = 1'b1
   } route_mode_e;
endpackage

// File: rtl/irq_arm_ctrl.sv
module irq_arm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   output logic armed_o
);
   // acknowledge has priority over a same-cycle re-arm
   always_ff @(posedge clk) begin
      if (!rst_n)     armed_o <= 1'b0;
      else if (ack_i) armed_o <= 1'b0;
      else if (set_i) armed_o <= 1'b1;
   end
endmodule

// File: rtl/irq_route_map.sv
module irq_route_map #(
   parameter int unsigned REQ_W   = 8,
   parameter int unsigned ERR_W   = 4,
   parameter int unsigned LINES   = 7,
   parameter int unsigned LEVEL_W = 3
) (
   input  logic [REQ_W-1:0]   req_i,
   input  logic [REQ_W-1:0]   req_en_i,
   input  logic [ERR_W-1:0]   err_i,
   input  logic [ERR_W-1:0]   err_en_i,
   input  logic               multi_i,
   input  logic [LEVEL_W-1:0] level_i,
   output logic [LINES-1:0]   line_o
);
   import irq_router_pkg::*;

   if (REQ_W < LINES) begin : g_bad_req_w
      $error("irq_route_map: fewer requests than bus lines");
   end
   if (LINES >= (1 << LEVEL_W)) begin : g_bad_level_w
      $error("irq_route_map: level field cannot address every line");
   end

   logic [REQ_W-1:0] req_act;
   logic [ERR_W-1:0] err_act;
   logic             any_act;

   assign req_act = req_i & req_en_i;
   assign err_act = err_i & err_en_i;
   assign any_act = (|req_act) | (|err_act);

   for (genvar j = 0; j < LINES; j++) begin : g_line
      localparam logic [LEVEL_W-1:0] CODE = LEVEL_W'(j + 1);
      logic shared_hit;
      assign shared_hit = any_act && (level_i == CODE);
      always_comb begin
         if (route_mode_e'(multi_i) == ROUTE_MULTI) line_o[j] = req_act[j];
         else                                       line_o[j] = shared_hit;
      end
   end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
   parameter int unsigned LINES = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed_i,
   input  logic [LINES-1:0] line_i,
   output logic [LINES-1:0] irq_n_o
);
   logic [LINES-1:0] gated;

   assign gated = armed_i ? line_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_n_o <= '1;
      else        irq_n_o <= ~gated;
   end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
   parameter int unsigned SITES        = irq_router_pkg::SITES,
   parameter int unsigned REQ_PER_SITE = irq_router_pkg::REQ_PER_SITE,
   parameter int unsigned LINES        = irq_router_pkg::BUS_LINES,
   parameter int unsigned LEVEL_W      = irq_router_pkg::LEVEL_W,
   localparam int unsigned REQ_W       = SITES * REQ_PER_SITE,
   localparam int unsigned ERR_W       = SITES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REQ_W-1:0]   req_i,
   input  logic [REQ_W-1:0]   req_en_i,
   input  logic [ERR_W-1:0]   err_i,
   input  logic [ERR_W-1:0]   err_en_i,
   input  logic               route_multi_i,
   input  logic [LEVEL_W-1:0] level_i,
   input  logic               arm_set_i,
   input  logic               iack_i,
   output logic [LINES-1:0]   irq_n_o,
   output logic               armed_o
);
   logic [LINES-1:0] line_req;

   irq_arm_ctrl u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (arm_set_i),
      .ack_i   (iack_i),
      .armed_o (armed_o)
   );

   irq_route_map #(
      .REQ_W   (REQ_W),
      .ERR_W   (ERR_W),
      .LINES   (LINES),
      .LEVEL_W (LEVEL_W)
   ) u_map (
      .req_i    (req_i),
      .req_en_i (req_en_i),
      .err_i    (err_i),
      .err_en_i (err_en_i),
      .multi_i  (route_multi_i),
      .level_i  (level_i),
      .line_o   (line_req)
   );

   irq_out_stage #(
      .LINES (LINES)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed_i (armed_o),
      .line_i  (line_req),
      .irq_n_o (irq_n_o)
   );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int unsigned REQ_W   = 8,
   parameter int unsigned ERR_W   = 4,
   parameter int unsigned LINES   = 7,
   parameter int unsigned LEVEL_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [REQ_W-1:0]   req_i,
   input logic [REQ_W-1:0]   req_en_i,
   input logic [ERR_W-1:0]   err_i,
   input logic [ERR_W-1:0]   err_en_i,
   input logic               route_multi_i,
   input logic [LEVEL_W-1:0] level_i,
   input logic               arm_set_i,
   input logic               iack_i,
   input logic [LINES-1:0]   irq_n_o,
   input logic               armed_o
);
   p_unarmed_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_o |=> (&irq_n_o));

   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      iack_i |=> !armed_o);

   p_set_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_set_i && !iack_i) |=> armed_o);

   p_multi_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && route_multi_i) |=>
         (irq_n_o == ~($past(req_i[LINES-1:0]) & $past(req_en_i[LINES-1:0]))));

   p_shared_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !route_multi_i |=> ($countones(~irq_n_o) <= 1));

   p_level_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!route_multi_i && level_i == '0) |=> (&irq_n_o));

   p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (((req_i & req_en_i) == '0) && ((err_i & err_en_i) == '0)) |=> (&irq_n_o));
endmodule

bind irq_router irq_router_chk #(
   .REQ_W   (REQ_W),
   .ERR_W   (ERR_W),
   .LINES   (LINES),
   .LEVEL_W (LEVEL_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_i         (req_i),
   .req_en_i      (req_en_i),
   .err_i         (err_i),
   .err_en_i      (err_en_i),
   .route_multi_i (route_multi_i),
   .level_i       (level_i),
   .arm_set_i     (arm_set_i),
   .iack_i        (iack_i),
   .irq_n_o       (irq_n_o),
   .armed_o       (armed_o)
);

// File: tb/irq_router_test.sv
module irq_router_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0, req_en = '0;
   logic [3:0] err = '0, err_en = '0;
   logic       multi = 1'b0;
   logic [2:0] level = '0;
   logic       arm_set = 1'b0, iack = 1'b0;
   logic [6:0] irq_n;
   logic       armed;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   bit    cmp_en = 0;
   string cur_req = "R10";

   logic [6:0] exp_irq_n = 7'h7f;
   bit         m_arm = 0;

   always #5 clk = ~clk;

   irq_router uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_en_i(req_en),
      .err_i(err), .err_en_i(err_en), .route_multi_i(multi),
      .level_i(level), .arm_set_i(arm_set), .iack_i(iack),
      .irq_n_o(irq_n), .armed_o(armed)
   );

   // behavioural reference: outputs reflect previous cycle's inputs
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_irq_n = 7'h7f;
         m_arm = 0;
      end else begin
         logic [6:0] want;
         want = 7'h7f;
         if (m_arm) begin
            if (multi) begin
               for (int j = 0; j < 7; j++)
                  if (req[j] && req_en[j]) want[j] = 1'b0;
            end else begin
               int hits;
               hits = 0;
               for (int j = 0; j < 8; j++) if (req[j] && req_en[j]) hits++;
               for (int j = 0; j < 4; j++) if (err[j] && err_en[j]) hits++;
               if (hits > 0 && level != 0) want[level - 1] = 1'b0;
            end
         end
         exp_irq_n = want;
         if (iack)         m_arm = 0;
         else if (arm_set) m_arm = 1;
      end
   end

   task automatic check(string rq, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         check(cur_req, 32'(irq_n), 32'(exp_irq_n), "irq_n");
         check(cur_req, 32'(armed), 32'(m_arm), "armed");
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic pulse_arm();
      arm_set = 1'b1; cyc(1); arm_set = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R10: reset state
      check("R10", 32'(irq_n), 32'h7f, "irq_n after reset");
      check("R10", 32'(armed), 32'h0, "armed after reset");
      cmp_en = 1;

      // R5: unarmed, everything requesting
      cur_req = "R5";
      multi = 1; req = 8'hff; req_en = 8'hff; err = 4'hf; err_en = 4'hf; level = 3;
      cyc(4);
      check("R5", 32'(irq_n), 32'h7f, "unarmed lines");

      // R1: per-line walk
      cur_req = "R1";
      req = '0; err = '0;
      pulse_arm();
      for (int j = 0; j < 7; j++) begin
         req = 8'(1 << j); cyc(1);
         check("R1", 32'(irq_n), 32'(7'h7f & ~(7'(1) << j)), "single request line");
      end

      // R2: ignored sources in per-line mode
      cur_req = "R2";
      req = 8'h80; err = 4'hf;
      for (int l = 0; l < 8; l++) begin
         level = 3'(l); cyc(1);
         check("R2", 32'(irq_n), 32'h7f, "last request, errors, level ignored");
      end

      // R4: masks in both modes
      cur_req = "R4";
      req = 8'hff; req_en = '0; err = 4'hf; err_en = '0; level = 5;
      multi = 1; cyc(2);
      check("R4", 32'(irq_n), 32'h7f, "all masked per-line");
      multi = 0; cyc(2);
      check("R4", 32'(irq_n), 32'h7f, "all masked shared");
      for (int i = 0; i < 40; i++) begin
         req = 8'($urandom); req_en = 8'($urandom);
         err = 4'($urandom); err_en = 4'($urandom);
         multi = 1'($urandom); level = 3'($urandom);
         cyc(1);
      end

      // R7: mode toggle with a fixed pattern
      cur_req = "R7";
      req = 8'h01; req_en = 8'hff; err = '0; err_en = 4'hf; level = 4;
      multi = 1; cyc(2);
      check("R7", 32'(irq_n), 32'h7e, "per-line routes to line 1");
      multi = 0; cyc(1);
      check("R7", 32'(irq_n), 32'h77, "shared routes to level 4");

      // R3: shared level sweep, error-only source
      cur_req = "R3";
      req = '0; err = 4'b0100; err_en = 4'b0100;
      for (int l = 1; l < 8; l++) begin
         level = 3'(l); cyc(1);
         check("R3", 32'(irq_n), 32'(7'h7f & ~(7'(1) << (l - 1))), "shared level line");
      end
      for (int i = 0; i < 30; i++) begin
         req = 8'($urandom); err = 4'($urandom); level = 3'($urandom); cyc(1);
      end

      // R8: level zero
      cur_req = "R8";
      req = 8'hff; err = 4'hf; level = 0; cyc(2);
      check("R8", 32'(irq_n), 32'h7f, "level zero quiet");

      // R6: acknowledge clears; same-cycle set and ack
      cur_req = "R6";
      level = 2;
      iack = 1; arm_set = 1; cyc(1); iack = 0; arm_set = 0;
      check("R6", 32'(armed), 32'h0, "ack wins over set");
      pulse_arm();
      check("R6", 32'(armed), 32'h1, "re-armed");

      // R9: deassert one cycle after arm falls, requests still active
      cur_req = "R9";
      multi = 1; req = 8'h7f; req_en = 8'hff; cyc(1);
      check("R9", 32'(irq_n), 32'h00, "all lines asserted");
      iack = 1; cyc(1); iack = 0;
      check("R9", 32'(armed), 32'h0, "armed cleared");
      check("R9", 32'(irq_n), 32'h00, "lines still low one cycle");
      cyc(1);
      check("R9", 32'(irq_n), 32'h7f, "lines high after arm fell");
      for (int i = 0; i < 60; i++) begin
         req = 8'($urandom); req_en = 8'($urandom); err = 4'($urandom);
         err_en = 4'($urandom); multi = 1'($urandom); level = 3'($urandom);
         arm_set = 1'($urandom); iack = (($urandom % 4) == 0);
         cyc(1);
      end
      arm_set = 0; iack = 0;
      cyc(2);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule